// File: doc/BRIEF.md
# Way-Prediction Validation and Fill Resolver

This block sits beside a set-associative data cache whose loads pick one way early, from a short hash of the linear address, before translation finishes. It has two independent jobs. First, once the physical tag of a load is known, it checks the guess. The guess stands only if a way was predicted and the physical tag stored in that way equals the load's physical tag. Any other outcome becomes a miss that asks the next cache level for the line.

Second, when that line returns, the resolver compares the fill's physical tag and hash against every valid way of the target set. It then decides where the line lands. A way whose hash collides is overwritten even when an empty way exists. A way that already holds the physical line under another hash only has its hash rewritten. When one way holds the physical tag and a different way holds the hash, the hash holder is dropped and the physical holder takes the new hash. When nothing matches, the external replacement policy's choice is used. Both results appear one clock after their request.

Top module: `wp_fill_resolver`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is cleared on that edge. This holds even when requests are asserted.
- R2: A validation request with `val_pred_hit`=1 and `val_way_ptag` equal to `val_acc_ptag` gives, one cycle later, `val_done`=1, `val_hit`=1, `val_fill_req`=0, and `val_hit_way` one-hot at bit `val_pred_way`.
- R3: A validation request with `val_pred_hit`=1 and differing tags gives, one cycle later, `val_hit`=0, `val_fill_req`=1 and `val_hit_way`=0.
- R4: A validation request with `val_pred_hit`=0 gives `val_fill_req`=1 and `val_hit`=0 one cycle later, whatever the tag inputs hold.
- R5: When no valid way matches the fill's physical tag or hash, the result is `res_case`=0. The write goes to the way numbered `repl_way`, with `res_used_repl`=1, `res_data_write`=1 and no invalidation.
- R6: When a valid way matches the hash and no valid way matches the physical tag, the result is `res_case`=1. The write goes to that hash-matching way with `res_data_write`=1 and `res_used_repl`=0, even while another way is invalid.
- R7: When a valid way matches the physical tag, and no valid way matches the hash or the same way matches both, the result is `res_case`=2. The write goes to that way with `res_data_write`=0, meaning only its hash is rewritten, and there is no invalidation.
- R8: When one valid way matches the physical tag and a different valid way matches the hash, the result is `res_case`=3. The write goes to the physical-tag way with `res_data_write`=0, the hash way is invalidated, and `res_used_repl`=0. Any invalid way is left untouched.
- R9: Ways with `set_valid` low never count as a match. When several ways match, the lowest-numbered one is taken.
- R10: With `res_valid`=1, `res_wr_way` has exactly one bit set, `res_inval` has at most one bit set, and the two never share a bit.
- R11: Each fill result appears exactly one cycle after `fill_valid`. In a cycle after no fill request, `res_valid`, `res_wr_way` and `res_inval` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| val_valid | input | 1 | Validation request strobe |
| val_pred_hit | input | 1 | A way was predicted for this load |
| val_pred_way | input | WAY_IDX_W | Predicted way number |
| val_way_ptag | input | PTAG_W | Physical tag stored in the predicted way |
| val_acc_ptag | input | PTAG_W | Physical tag of the load |
| val_done | output | 1 | Validation result valid |
| val_hit | output | 1 | Prediction confirmed |
| val_hit_way | output | NUM_WAYS | One-hot confirmed way |
| val_fill_req | output | 1 | Miss, fill request needed |
| fill_valid | input | 1 | Fill resolution request strobe |
| fill_ptag | input | PTAG_W | Physical tag of the returning line |
| fill_hash | input | HASH_W | Hash of the linear address of the fill |
| set_valid | input | NUM_WAYS | Valid bit per way of the set |
| set_ptag | input | NUM_WAYS*PTAG_W | Physical tags of the set, way w at bits w*PTAG_W upward |
| set_hash | input | NUM_WAYS*HASH_W | Hash tags of the set, way w at bits w*HASH_W upward |
| repl_way | input | WAY_IDX_W | Victim way chosen by the replacement policy |
| res_valid | output | 1 | Fill resolution valid |
| res_wr_way | output | NUM_WAYS | One-hot way to write |
| res_inval | output | NUM_WAYS | One-hot way to invalidate, or zero |
| res_data_write | output | 1 | 1: write data, tags and hash; 0: rewrite hash only |
| res_used_repl | output | 1 | The replacement policy's choice was used |
| res_case | output | 2 | 0 new, 1 hash collision, 2 alias, 3 mixed |

## Verification
The bench builds the block with four ways, a 10-bit physical tag and a 3-bit hash. The short hash makes collisions between unrelated lines easy to build. The small set lets a single test show all placement cases in one set, including a free way left unused beside a collision. A randomized phase draws tags and hashes from tiny ranges, so multiple matches, invalid matching entries and the lowest-index rule all come up often.

// File: rtl/wpfr_pkg.sv
// Shared types for the way-prediction validation and fill resolver.
package wpfr_pkg;
    // Placement outcome of a fill; the encoding is visible on res_case.
    typedef enum logic [1:0] {
        FILL_NEW       = 2'd0,
        FILL_HASH_HIT  = 2'd1,
        FILL_ALIAS     = 2'd2,
        FILL_MIXED     = 2'd3
    } fill_case_e;
endpackage

// File: rtl/wpfr_validate.sv
// Prediction check: confirms a predicted way when its stored physical tag
// equals the access tag, otherwise reports a miss needing a fill.
// Assumes the stored tag is already read from the predicted way.
module wpfr_validate #(
    parameter int NUM_WAYS = 8,
    parameter int PTAG_W   = 30,
    localparam int WAY_IDX_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                 pred_hit,
    input  logic [WAY_IDX_W-1:0] pred_way,
    input  logic [PTAG_W-1:0]    way_ptag,
    input  logic [PTAG_W-1:0]    acc_ptag,
    output logic                 hit,
    output logic                 need_fill,
    output logic [NUM_WAYS-1:0]  hit_way
);
    // Compare the stored tag against the translated tag.
    always_comb begin
        hit       = pred_hit && (way_ptag == acc_ptag);
        need_fill = !hit;
    end

    // Decode the confirmed way number to one-hot form.
    always_comb begin
        hit_way = '0;
        for (int unsigned w = 0; w < NUM_WAYS; w++) begin
            if (hit && (pred_way == WAY_IDX_W'(w))) begin
                hit_way[w] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wpfr_match.sv
// Per-way comparators: flags each valid way whose physical tag or hash tag
// equals the fill's. Invalid ways never match. Tags arrive flattened.
module wpfr_match #(
    parameter int NUM_WAYS = 8,
    parameter int PTAG_W   = 30,
    parameter int HASH_W   = 8
) (
    input  logic [NUM_WAYS-1:0]        set_valid,
    input  logic [NUM_WAYS*PTAG_W-1:0] set_ptag,
    input  logic [NUM_WAYS*HASH_W-1:0] set_hash,
    input  logic [PTAG_W-1:0]          fill_ptag,
    input  logic [HASH_W-1:0]          fill_hash,
    output logic [NUM_WAYS-1:0]        ptag_hit,
    output logic [NUM_WAYS-1:0]        hash_hit
);
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        // One comparator pair per way, qualified by the valid bit.
        always_comb begin
            ptag_hit[w] = set_valid[w] && (set_ptag[w*PTAG_W +: PTAG_W] == fill_ptag);
            hash_hit[w] = set_valid[w] && (set_hash[w*HASH_W +: HASH_W] == fill_hash);
        end
    end
endmodule

// File: rtl/wpfr_first.sv
// Lowest-index pick: reduces a match vector to one-hot plus an any flag.
// Assumes nothing about how many bits are set.
module wpfr_first #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] vec,
    output logic [WIDTH-1:0] first,
    output logic             any
);
    // Scan upward and keep only the first set bit.
    always_comb begin
        first = '0;
        any   = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (vec[i] && !any) begin
                first[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wpfr_place.sv
// Placement decision for a returning fill from the one-hot physical-tag
// match, the one-hot hash match and the replacement policy's victim.
// Assumes match inputs are one-hot or zero.
module wpfr_place
    import wpfr_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    localparam int WAY_IDX_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0]  p_oh,
    input  logic                 p_any,
    input  logic [NUM_WAYS-1:0]  h_oh,
    input  logic                 h_any,
    input  logic [WAY_IDX_W-1:0] repl_way,
    output logic [NUM_WAYS-1:0]  wr_way,
    output logic [NUM_WAYS-1:0]  inval,
    output logic                 data_write,
    output logic                 used_repl,
    output fill_case_e           fcase
);
    logic [NUM_WAYS-1:0] repl_oh;

    // Decode the replacement victim to one-hot form.
    always_comb begin
        repl_oh = '0;
        for (int unsigned w = 0; w < NUM_WAYS; w++) begin
            repl_oh[w] = (repl_way == WAY_IDX_W'(w));
        end
    end

    // Classify the fill and select the target and invalidate ways.
    always_comb begin
        wr_way     = '0;
        inval      = '0;
        data_write = 1'b0;
        used_repl  = 1'b0;
        fcase      = FILL_NEW;
        if (!p_any && !h_any) begin
            wr_way     = repl_oh;
            data_write = 1'b1;
            used_repl  = 1'b1;
            fcase      = FILL_NEW;
        end else if (!p_any) begin
            wr_way     = h_oh;
            data_write = 1'b1;
            fcase      = FILL_HASH_HIT;
        end else if (!h_any || (h_oh == p_oh)) begin
            wr_way     = p_oh;
            fcase      = FILL_ALIAS;
        end else begin
            wr_way     = p_oh;
            inval      = h_oh;
            fcase      = FILL_MIXED;
        end
    end
endmodule

// File: rtl/wp_fill_resolver.sv
// Top: validates way predictions and resolves fill placement, each result
// registered one cycle after its request. Synchronous active-low reset.
// Assumes the set contents presented with a fill are stable that cycle.
module wp_fill_resolver
    import wpfr_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    parameter int PTAG_W   = 30,
    parameter int HASH_W   = 8,
    localparam int WAY_IDX_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         val_valid,
    input  logic                         val_pred_hit,
    input  logic [WAY_IDX_W-1:0]         val_pred_way,
    input  logic [PTAG_W-1:0]            val_way_ptag,
    input  logic [PTAG_W-1:0]            val_acc_ptag,
    output logic                         val_done,
    output logic                         val_hit,
    output logic [NUM_WAYS-1:0]          val_hit_way,
    output logic                         val_fill_req,
    input  logic                         fill_valid,
    input  logic [PTAG_W-1:0]            fill_ptag,
    input  logic [HASH_W-1:0]            fill_hash,
    input  logic [NUM_WAYS-1:0]          set_valid,
    input  logic [NUM_WAYS*PTAG_W-1:0]   set_ptag,
    input  logic [NUM_WAYS*HASH_W-1:0]   set_hash,
    input  logic [WAY_IDX_W-1:0]         repl_way,
    output logic                         res_valid,
    output logic [NUM_WAYS-1:0]          res_wr_way,
    output logic [NUM_WAYS-1:0]          res_inval,
    output logic                         res_data_write,
    output logic                         res_used_repl,
    output logic [1:0]                   res_case
);
    logic                hit_c;
    logic                need_fill_c;
    logic [NUM_WAYS-1:0] hit_way_c;
    logic [NUM_WAYS-1:0] ptag_hit;
    logic [NUM_WAYS-1:0] hash_hit;
    logic [NUM_WAYS-1:0] p_oh;
    logic [NUM_WAYS-1:0] h_oh;
    logic                p_any;
    logic                h_any;
    logic [NUM_WAYS-1:0] wr_c;
    logic [NUM_WAYS-1:0] inval_c;
    logic                data_c;
    logic                repl_c;
    fill_case_e          case_c;

    wpfr_validate #(.NUM_WAYS(NUM_WAYS), .PTAG_W(PTAG_W)) u_validate (
        .pred_hit  (val_pred_hit),
        .pred_way  (val_pred_way),
        .way_ptag  (val_way_ptag),
        .acc_ptag  (val_acc_ptag),
        .hit       (hit_c),
        .need_fill (need_fill_c),
        .hit_way   (hit_way_c)
    );

    wpfr_match #(.NUM_WAYS(NUM_WAYS), .PTAG_W(PTAG_W), .HASH_W(HASH_W)) u_match (
        .set_valid (set_valid),
        .set_ptag  (set_ptag),
        .set_hash  (set_hash),
        .fill_ptag (fill_ptag),
        .fill_hash (fill_hash),
        .ptag_hit  (ptag_hit),
        .hash_hit  (hash_hit)
    );

    wpfr_first #(.WIDTH(NUM_WAYS)) u_first_p (
        .vec   (ptag_hit),
        .first (p_oh),
        .any   (p_any)
    );

    wpfr_first #(.WIDTH(NUM_WAYS)) u_first_h (
        .vec   (hash_hit),
        .first (h_oh),
        .any   (h_any)
    );

    wpfr_place #(.NUM_WAYS(NUM_WAYS)) u_place (
        .p_oh       (p_oh),
        .p_any      (p_any),
        .h_oh       (h_oh),
        .h_any      (h_any),
        .repl_way   (repl_way),
        .wr_way     (wr_c),
        .inval      (inval_c),
        .data_write (data_c),
        .used_repl  (repl_c),
        .fcase      (case_c)
    );

    // Register the validation result for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_done     <= 1'b0;
            val_hit      <= 1'b0;
            val_hit_way  <= '0;
            val_fill_req <= 1'b0;
        end else begin
            val_done     <= val_valid;
            val_hit      <= val_valid && hit_c;
            val_hit_way  <= val_valid ? hit_way_c : '0;
            val_fill_req <= val_valid && need_fill_c;
        end
    end

    // Register the fill placement for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid      <= 1'b0;
            res_wr_way     <= '0;
            res_inval      <= '0;
            res_data_write <= 1'b0;
            res_used_repl  <= 1'b0;
            res_case       <= 2'd0;
        end else begin
            res_valid      <= fill_valid;
            res_wr_way     <= fill_valid ? wr_c : '0;
            res_inval      <= fill_valid ? inval_c : '0;
            res_data_write <= fill_valid && data_c;
            res_used_repl  <= fill_valid && repl_c;
            res_case       <= fill_valid ? case_c : 2'd0;
        end
    end
endmodule

// File: rtl/wpfr_checker.sv
// Property checker for wp_fill_resolver, attached through bind below.
module wpfr_checker #(
    parameter int NUM_WAYS = 8,
    parameter int PTAG_W   = 30,
    localparam int WAY_IDX_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 val_valid,
    input logic                 val_pred_hit,
    input logic [WAY_IDX_W-1:0] val_pred_way,
    input logic [PTAG_W-1:0]    val_way_ptag,
    input logic [PTAG_W-1:0]    val_acc_ptag,
    input logic                 val_done,
    input logic                 val_hit,
    input logic [NUM_WAYS-1:0]  val_hit_way,
    input logic                 val_fill_req,
    input logic                 fill_valid,
    input logic                 res_valid,
    input logic [NUM_WAYS-1:0]  res_wr_way,
    input logic [NUM_WAYS-1:0]  res_inval,
    input logic                 res_data_write,
    input logic                 res_used_repl,
    input logic [1:0]           res_case
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!val_done && !res_valid)); // R1
    AST_CONFIRM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (val_valid && val_pred_hit && (val_way_ptag == val_acc_ptag)) |=> (val_hit && !val_fill_req)); // R2
    AST_HIT_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        (val_valid && val_pred_hit) |=> (!val_hit || (val_hit_way == (NUM_WAYS'(1) << $past(val_pred_way))))); // R2
    AST_VAL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        val_done |-> (val_hit != val_fill_req)); // R3
    AST_NO_PRED_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (val_valid && !val_pred_hit) |=> (val_fill_req && !val_hit)); // R4
    AST_REPL_ONLY_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_used_repl) |-> (res_case == 2'd0 && res_data_write)); // R5
    AST_HASH_ONLY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_case[1]) |-> !res_data_write); // R7
    AST_MIXED_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_case == 2'd3) |-> ($countones(res_inval) == 1 && !res_used_repl)); // R8
    AST_WR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones(res_wr_way) == 1)); // R10
    AST_INVAL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_inval)); // R10
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (res_wr_way & res_inval) == '0); // R10
    AST_FILL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> res_valid); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_wr_way == '0 && res_inval == '0)); // R11
endmodule

bind wp_fill_resolver wpfr_checker #(.NUM_WAYS(NUM_WAYS), .PTAG_W(PTAG_W)) u_wpfr_checker (.*);

// File: tb/test_wp_fill_resolver.sv
module test_wp_fill_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int PW = 10;
    localparam int HW = 3;
    localparam int IW = 2;
    localparam int WATCHDOG = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             val_valid = 1'b0;
    logic             val_pred_hit = 1'b0;
    logic [IW-1:0]    val_pred_way = '0;
    logic [PW-1:0]    val_way_ptag = '0;
    logic [PW-1:0]    val_acc_ptag = '0;
    logic             val_done;
    logic             val_hit;
    logic [NW-1:0]    val_hit_way;
    logic             val_fill_req;
    logic             fill_valid = 1'b0;
    logic [PW-1:0]    fill_ptag = '0;
    logic [HW-1:0]    fill_hash = '0;
    logic [NW-1:0]    set_valid = '0;
    logic [NW*PW-1:0] set_ptag = '0;
    logic [NW*HW-1:0] set_hash = '0;
    logic [IW-1:0]    repl_way = '0;
    logic             res_valid;
    logic [NW-1:0]    res_wr_way;
    logic [NW-1:0]    res_inval;
    logic             res_data_write;
    logic             res_used_repl;
    logic [1:0]       res_case;

    wp_fill_resolver #(.NUM_WAYS(NW), .PTAG_W(PW), .HASH_W(HW)) i_wp_fill_resolver (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;
    string tag = "R1";

    // Expected outputs, computed from the requirements.
    logic          e_done, e_hit, e_fill, e_rvalid, e_data, e_repl;
    logic [NW-1:0] e_hway, e_wr, e_inv;
    logic [1:0]    e_case;

    task automatic model();
        int p, h;
        p = -1; h = -1;
        e_done = 0; e_hit = 0; e_fill = 0; e_hway = '0;
        e_rvalid = 0; e_wr = '0; e_inv = '0; e_data = 0; e_repl = 0; e_case = 0;
        if (!rst_n) return;
        if (val_valid) begin
            e_done = 1;
            if (val_pred_hit && val_way_ptag == val_acc_ptag) begin
                e_hit = 1;
                e_hway[val_pred_way] = 1'b1;
            end else begin
                e_fill = 1;
            end
        end
        if (fill_valid) begin
            e_rvalid = 1;
            for (int w = NW - 1; w >= 0; w--) begin
                if (set_valid[w] && set_ptag[w*PW +: PW] == fill_ptag) p = w;
                if (set_valid[w] && set_hash[w*HW +: HW] == fill_hash) h = w;
            end
            if (p < 0 && h < 0) begin
                e_wr[repl_way] = 1'b1; e_data = 1; e_repl = 1; e_case = 0;
            end else if (p < 0) begin
                e_wr[h] = 1'b1; e_data = 1; e_case = 1;
            end else if (h < 0 || h == p) begin
                e_wr[p] = 1'b1; e_case = 2;
            end else begin
                e_wr[p] = 1'b1; e_inv[h] = 1'b1; e_case = 3;
            end
        end
    endtask

    task automatic compare();
        checks++;
        if ({val_done, val_hit, val_fill_req, val_hit_way} !== {e_done, e_hit, e_fill, e_hway}) begin
            fails++;
            $display("FAIL %s validation: got done=%b hit=%b fill=%b way=%b, expected done=%b hit=%b fill=%b way=%b",
                     tag, val_done, val_hit, val_fill_req, val_hit_way, e_done, e_hit, e_fill, e_hway);
        end
        checks++;
        if ({res_valid, res_wr_way, res_inval, res_data_write, res_used_repl, res_case} !==
            {e_rvalid, e_wr, e_inv, e_data, e_repl, e_case}) begin
            fails++;
            $display("FAIL %s fill: got v=%b wr=%b inv=%b data=%b repl=%b case=%0d, expected v=%b wr=%b inv=%b data=%b repl=%b case=%0d",
                     tag, res_valid, res_wr_way, res_inval, res_data_write, res_used_repl, res_case,
                     e_rvalid, e_wr, e_inv, e_data, e_repl, e_case);
        end
    endtask

    // Inputs are already applied; model them, let one edge pass, compare.
    task automatic tick();
        model();
        @(negedge clk);
        compare();
    endtask

    task automatic way(input int w, input bit v, input int p, input int h);
        set_valid[w] = v;
        set_ptag[w*PW +: PW] = PW'(p);
        set_hash[w*HW +: HW] = HW'(h);
    endtask

    task automatic idle();
        val_valid = 0; fill_valid = 0;
    endtask

    task automatic fill(input int p, input int h, input int r);
        fill_valid = 1; fill_ptag = PW'(p); fill_hash = HW'(h); repl_way = IW'(r);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                checks++; fails++;
                $display("FAIL watchdog expired: got %0d cycles, expected at most %0d", cycles, WATCHDOG);
                report();
            end
        end
    end

    initial begin
        @(negedge clk);
        // R1: requests during reset must not reach the outputs.
        tag = "R1";
        val_valid = 1; val_pred_hit = 1; val_way_ptag = 10'd5; val_acc_ptag = 10'd5;
        way(0, 1, 7, 2); fill(7, 2, 0);
        tick(); tick();
        idle(); rst_n = 1; tick();

        // R2: confirmed prediction.
        tag = "R2";
        val_valid = 1; val_pred_hit = 1; val_pred_way = 2'd3; val_way_ptag = 10'h155; val_acc_ptag = 10'h155;
        tick();
        // R3: prediction with the wrong physical tag.
        tag = "R3";
        val_acc_ptag = 10'h154; tick();
        // R4: no prediction, tags equal yet still a miss.
        tag = "R4";
        val_pred_hit = 0; val_acc_ptag = 10'h155; tick();
        idle(); tick();

        // R5: nothing matches, replacement victim used.
        tag = "R5";
        way(0, 1, 10, 1); way(1, 1, 11, 2); way(2, 1, 12, 3); way(3, 1, 13, 4);
        fill(20, 5, 2); tick();
        way(1, 0, 0, 0); fill(21, 6, 0); tick();
        // R6: hash collision overrides a free way.
        tag = "R6";
        way(1, 0, 0, 0); fill(30, 4, 1); tick();
        // R7: physical line present under another hash.
        tag = "R7";
        fill(12, 7, 0); tick();
        // R7: same way matches both tag and hash.
        fill(12, 3, 1); tick();
        // R8: tag in one way, hash in another, free way ignored.
        tag = "R8";
        fill(11, 1, 1); way(1, 1, 11, 2); way(2, 0, 0, 0); tick();
        // R9: invalid entries carrying matching values are ignored.
        tag = "R9";
        way(0, 0, 50, 6); way(1, 0, 51, 6); way(2, 1, 52, 0); way(3, 1, 50, 1);
        fill(51, 6, 1); tick();
        // R9: lowest matching way wins.
        way(0, 1, 60, 5); way(1, 1, 61, 5); way(2, 1, 62, 5); way(3, 1, 63, 5);
        fill(99, 5, 3); tick();
        // R11: results vanish the cycle after the request ends.
        tag = "R11";
        idle(); tick();
        fill(62, 0, 0); tick(); idle(); tick();

        // R10: randomized sets over small tag ranges.
        tag = "R10";
        for (int n = 0; n < 400; n++) begin
            for (int w = 0; w < NW; w++) way(w, $urandom_range(0, 1) == 1, $urandom_range(0, 5), $urandom_range(0, 3));
            fill_valid = $urandom_range(0, 3) != 0;
            fill_ptag = PW'($urandom_range(0, 5)); fill_hash = HW'($urandom_range(0, 3));
            repl_way = IW'($urandom_range(0, NW - 1));
            val_valid = $urandom_range(0, 1) == 1; val_pred_hit = $urandom_range(0, 1) == 1;
            val_pred_way = IW'($urandom_range(0, NW - 1));
            val_way_ptag = PW'($urandom_range(0, 2)); val_acc_ptag = PW'($urandom_range(0, 2));
            tick();
        end
        idle(); tick();
        report();
    end
endmodule